// File: doc/BRIEF.md
# ATA Device Probe and Soft-Reset Sequencer

This block drives the bring-up of a parallel ATA channel. It sits above a PIO cycle engine and talks to it through a request/done handshake. Each request carries one register access: a direction, a 4-bit register select and a write byte. When a start command arrives, the block first finds out which of the two devices on the cable answer. It then pulses the software-reset bit in the device control register and waits for the drives to leave the busy state.

The block reports three things: a two-bit presence mask, a one-cycle completion pulse, and two sticky error flags (deadline expired, no device). Every delay is counted in pulses of an external microsecond tick, so a testbench can shrink the intervals through parameters. The busy-wait deadline is an input.

Register select codes used on the engine port are 2 = sector count, 3 = LBA low, 6 = device/head, 7 = status, and 0xE = device control.

Top module: `ate_probe_seq`

## Requirements
- R1: After reset, busy_o, done_o, eng_req_o, present_o, err_timeout_o and err_nodev_o are all 0.
- R2: Before each device's presence test the block writes the device register (code 6) with 0xA0 for device 0 or 0xB0 for device 1, where bit 4 selects device 1.
- R3: A presence test writes sector count (code 2) and LBA low (code 3) alternately with 0x55/0xAA, then 0xAA/0x55, then 0x55/0xAA. It then reads sector count and then LBA low.
- R4: A device's presence bit is set only when that readback returns 0x55 from sector count and 0xAA from LBA low.
- R5: Device 1 is tested only when slave_ok_i is 1. After the tests, device 0 is selected again by writing 0xA0.
- R6: Soft reset writes the control register (code 0xE) three times: ctl_i with bit 2 clear, ctl_i with bit 2 set, and ctl_i with bit 2 clear. Each write starts at least SRST_TICKS ticks after the previous one.
- R7: The first status read (code 7) starts at least SETTLE_TICKS ticks after the last control write. Status is then re-read until bit 7 (BSY) is clear. This poll on device 0 happens in every run.
- R8: If device 1 is present, the block writes 0xB0 and then reads the sector count / LBA low pair up to SIG_TRIES (2) times. It stops early when both read 1, and waits at least RETRY_TICKS ticks after each failed pair. It then polls status on device 1 until BSY clears.
- R9: A status read of 0xFF ends the run. On device 0 it sets err_nodev_o. On device 1 it clears presence bit 1 and raises no error.
- R10: If a status poll still shows BSY after limit_i ticks of polling, err_timeout_o is set and the run ends.
- R11: busy_o is 1 during a run. done_o pulses for exactly one cycle at the end, with busy_o at 0. A start while busy is ignored.
- R12: Once raised, eng_req_o stays high with a stable select, direction and write byte until eng_done_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a probe and reset run (taken when idle) |
| slave_ok_i | input | 1 | A second device may exist on the cable |
| ctl_i | input | 8 | Base device control byte |
| limit_i | input | DLW | BSY-wait deadline, in ticks |
| tick_i | input | 1 | Microsecond timebase pulse |
| eng_req_o | output | 1 | Access request to the cycle engine |
| eng_we_o | output | 1 | 1 = write, 0 = read |
| eng_reg_o | output | 4 | Register select code |
| eng_wdata_o | output | 8 | Write byte |
| eng_done_i | input | 1 | Engine finished the access |
| eng_rdata_i | input | 8 | Read byte, valid with eng_done_i |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| present_o | output | 2 | Presence mask, bit n = device n |
| err_timeout_o | output | 1 | A BSY wait passed its deadline |
| err_nodev_o | output | 1 | Device 0 status read as 0xFF |

## Verification
The assertions assume that the cycle engine raises eng_done_i only while a request is pending, and only once per request. They also assume that slave_ok_i, ctl_i and limit_i stay constant for the length of a run.

The bench's engine model answers every request exactly once, two cycles after it appears. It changes the configuration inputs only while the block is idle, and it pulses tick_i every fourth clock. A second start is issued in the middle of one run only to show that it is ignored. It never overlaps the completion pulse.

// File: rtl/ate_pkg.sv
package ate_pkg;

    localparam logic [3:0] REG_NSECT = 4'h2;
    localparam logic [3:0] REG_LBAL  = 4'h3;
    localparam logic [3:0] REG_DEV   = 4'h6;
    localparam logic [3:0] REG_STAT  = 4'h7;
    localparam logic [3:0] REG_CTL   = 4'hE;

    localparam logic [7:0] DEV_OBS   = 8'hA0;
    localparam logic [7:0] DEV_ONE   = 8'h10;
    localparam logic [7:0] CTL_SRST  = 8'h04;
    localparam logic [7:0] PAT_A     = 8'h55;
    localparam logic [7:0] PAT_B     = 8'hAA;
    localparam logic [7:0] STAT_GONE = 8'hFF;
    localparam int         STAT_BSY  = 7;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL, S_PAT, S_RDNS, S_RDLB, S_SEL0, S_CTL, S_CTLWAIT,
        S_SETTLE, S_POLL, S_SEL1, S_SIGNS, S_SIGLB, S_RETRY, S_DONE
    } seq_state_t;

    typedef struct packed {
        logic       we;
        logic [3:0] rsel;
        logic [7:0] data;
    } acc_t;

    function automatic logic [7:0] dev_sel(input logic d);
        return DEV_OBS | (d ? DEV_ONE : 8'h00);
    endfunction

    // step 0..5: even steps hit sector count, odd steps LBA low;
    // the middle pair is swapped
    function automatic acc_t pat_acc(input logic [2:0] step);
        acc_t a;
        logic swap;
        swap   = (step[2:1] == 2'd1);
        a.we   = 1'b1;
        a.rsel = step[0] ? REG_LBAL : REG_NSECT;
        a.data = (step[0] ^ swap) ? PAT_B : PAT_A;
        return a;
    endfunction

    function automatic logic [7:0] srst_ctl(input logic [7:0] base, input logic hold);
        return hold ? (base | CTL_SRST) : (base & ~CTL_SRST);
    endfunction

    function automatic logic needs_access(input seq_state_t s);
        return !(s inside {S_IDLE, S_CTLWAIT, S_SETTLE, S_RETRY, S_DONE});
    endfunction

endpackage

// File: rtl/ate_access.sv
module ate_access
    import ate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_i,
    input  acc_t       cmd_i,
    output logic       eng_req_o,
    output acc_t       eng_cmd_o,
    input  logic       eng_done_i,
    input  logic [7:0] eng_rdata_i,
    output logic       fin_o,
    output logic [7:0] rd_o
);
    logic pend_q;
    acc_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cur_q  <= '0;
            fin_o  <= 1'b0;
            rd_o   <= '0;
        end else begin
            fin_o <= 1'b0;
            if (issue_i && !pend_q) begin
                cur_q  <= cmd_i;
                pend_q <= 1'b1;
            end else if (pend_q && eng_done_i) begin
                pend_q <= 1'b0;
                fin_o  <= 1'b1;
                rd_o   <= eng_rdata_i;
            end
        end
    end

    assign eng_req_o = pend_q;
    assign eng_cmd_o = cur_q;
endmodule

// File: rtl/ate_ticker.sv
module ate_ticker #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_o <= '0;
        else if (tick_i && cnt_o != {W{1'b1}})
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/ate_seq_fsm.sv
module ate_seq_fsm
    import ate_pkg::*;
#(
    parameter int TW           = 20,
    parameter int DLW          = 20,
    parameter int SRST_TICKS   = 20,
    parameter int SETTLE_TICKS = 150000,
    parameter int RETRY_TICKS  = 50000,
    parameter int SIG_TRIES    = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           slave_ok_i,
    input  logic [7:0]     ctl_i,
    input  logic [DLW-1:0] limit_i,
    input  logic           fin_i,
    input  logic [7:0]     rd_i,
    input  logic [TW-1:0]  wcnt_i,
    input  logic [DLW-1:0] dcnt_i,
    output logic           issue_o,
    output acc_t           cmd_o,
    output logic           wclr_o,
    output logic           dclr_o,
    output logic           busy_o,
    output logic           done_o,
    output logic [1:0]     present_o,
    output logic           err_to_o,
    output logic           err_nd_o
);
    localparam int TRW = $clog2(SIG_TRIES + 1);
    localparam logic [TW-1:0]  SRST_LIM   = TW'(SRST_TICKS);
    localparam logic [TW-1:0]  SETTLE_LIM = TW'(SETTLE_TICKS);
    localparam logic [TW-1:0]  RETRY_LIM  = TW'(RETRY_TICKS);
    localparam logic [TRW-1:0] TRY_LIM    = TRW'(SIG_TRIES);

    seq_state_t     st;
    logic           issued;
    logic           dev;
    logic [2:0]     step;
    logic [1:0]     phase;
    logic [TRW-1:0] tries;
    logic [7:0]     ns_q;

    always_comb begin
        cmd_o = '0;
        unique case (st)
            S_SEL:  begin cmd_o.we = 1'b1; cmd_o.rsel = REG_DEV; cmd_o.data = dev_sel(dev);  end
            S_SEL0: begin cmd_o.we = 1'b1; cmd_o.rsel = REG_DEV; cmd_o.data = dev_sel(1'b0); end
            S_SEL1: begin cmd_o.we = 1'b1; cmd_o.rsel = REG_DEV; cmd_o.data = dev_sel(1'b1); end
            S_PAT:  cmd_o = pat_acc(step);
            S_RDNS, S_SIGNS: cmd_o.rsel = REG_NSECT;
            S_RDLB, S_SIGLB: cmd_o.rsel = REG_LBAL;
            S_CTL:  begin
                cmd_o.we   = 1'b1;
                cmd_o.rsel = REG_CTL;
                cmd_o.data = srst_ctl(ctl_i, phase == 2'd1);
            end
            S_POLL: cmd_o.rsel = REG_STAT;
            default: cmd_o = '0;
        endcase
    end

    assign issue_o = needs_access(st) && !issued;
    assign busy_o  = (st != S_IDLE) && (st != S_DONE);
    assign done_o  = (st == S_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            issued    <= 1'b0;
            dev       <= 1'b0;
            step      <= '0;
            phase     <= '0;
            tries     <= '0;
            ns_q      <= '0;
            present_o <= '0;
            err_to_o  <= 1'b0;
            err_nd_o  <= 1'b0;
            wclr_o    <= 1'b0;
            dclr_o    <= 1'b0;
        end else begin
            wclr_o <= 1'b0;
            dclr_o <= 1'b0;
            if (issue_o) issued <= 1'b1;
            if (fin_i)   issued <= 1'b0;
            unique case (st)
                S_IDLE: if (start_i) begin
                    present_o <= '0;
                    err_to_o  <= 1'b0;
                    err_nd_o  <= 1'b0;
                    dev       <= 1'b0;
                    st        <= S_SEL;
                end
                S_SEL: if (fin_i) begin
                    step <= '0;
                    st   <= S_PAT;
                end
                S_PAT: if (fin_i) begin
                    if (step == 3'd5) st <= S_RDNS;
                    else              step <= step + 3'd1;
                end
                S_RDNS: if (fin_i) begin
                    ns_q <= rd_i;
                    st   <= S_RDLB;
                end
                S_RDLB: if (fin_i) begin
                    present_o[dev] <= (ns_q == PAT_A) && (rd_i == PAT_B);
                    if (!dev && slave_ok_i) begin
                        dev <= 1'b1;
                        st  <= S_SEL;
                    end else begin
                        st  <= S_SEL0;
                    end
                end
                S_SEL0: if (fin_i) begin
                    dev   <= 1'b0;
                    phase <= '0;
                    st    <= S_CTL;
                end
                S_CTL: if (fin_i) begin
                    wclr_o <= 1'b1;
                    st     <= (phase == 2'd2) ? S_SETTLE : S_CTLWAIT;
                end
                S_CTLWAIT: if (!wclr_o && wcnt_i >= SRST_LIM) begin
                    phase <= phase + 2'd1;
                    st    <= S_CTL;
                end
                S_SETTLE: if (!wclr_o && wcnt_i >= SETTLE_LIM) begin
                    dclr_o <= 1'b1;
                    st     <= S_POLL;
                end
                S_POLL: if (fin_i) begin
                    if (rd_i == STAT_GONE) begin
                        if (!dev) err_nd_o     <= 1'b1;
                        else      present_o[1] <= 1'b0;
                        st <= S_DONE;
                    end else if (!rd_i[STAT_BSY]) begin
                        if (!dev && present_o[1]) begin
                            dev   <= 1'b1;
                            tries <= '0;
                            st    <= S_SEL1;
                        end else begin
                            st <= S_DONE;
                        end
                    end else if (dcnt_i >= limit_i) begin
                        err_to_o <= 1'b1;
                        st       <= S_DONE;
                    end
                end
                S_SEL1: if (fin_i) st <= S_SIGNS;
                S_SIGNS: if (fin_i) begin
                    ns_q <= rd_i;
                    st   <= S_SIGLB;
                end
                S_SIGLB: if (fin_i) begin
                    if (ns_q == 8'h01 && rd_i == 8'h01) begin
                        dclr_o <= 1'b1;
                        st     <= S_POLL;
                    end else begin
                        tries  <= tries + 1'b1;
                        wclr_o <= 1'b1;
                        st     <= S_RETRY;
                    end
                end
                S_RETRY: if (!wclr_o && wcnt_i >= RETRY_LIM) begin
                    if (tries >= TRY_LIM) begin
                        dclr_o <= 1'b1;
                        st     <= S_POLL;
                    end else begin
                        st <= S_SIGNS;
                    end
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ate_probe_seq.sv
module ate_probe_seq
    import ate_pkg::*;
#(
    parameter int TW           = 20,
    parameter int DLW          = 20,
    parameter int SRST_TICKS   = 20,
    parameter int SETTLE_TICKS = 150000,
    parameter int RETRY_TICKS  = 50000,
    parameter int SIG_TRIES    = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           slave_ok_i,
    input  logic [7:0]     ctl_i,
    input  logic [DLW-1:0] limit_i,
    input  logic           tick_i,
    output logic           eng_req_o,
    output logic           eng_we_o,
    output logic [3:0]     eng_reg_o,
    output logic [7:0]     eng_wdata_o,
    input  logic           eng_done_i,
    input  logic [7:0]     eng_rdata_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [1:0]     present_o,
    output logic           err_timeout_o,
    output logic           err_nodev_o
);
    logic           issue, fin, wclr, dclr;
    logic [7:0]     rd;
    acc_t           cmd, eng_cmd;
    logic [TW-1:0]  wcnt;
    logic [DLW-1:0] dcnt;

    ate_seq_fsm #(
        .TW(TW), .DLW(DLW), .SRST_TICKS(SRST_TICKS), .SETTLE_TICKS(SETTLE_TICKS),
        .RETRY_TICKS(RETRY_TICKS), .SIG_TRIES(SIG_TRIES)
    ) fsm_i (
        .clk(clk), .rst(rst), .start_i(start_i), .slave_ok_i(slave_ok_i),
        .ctl_i(ctl_i), .limit_i(limit_i), .fin_i(fin), .rd_i(rd),
        .wcnt_i(wcnt), .dcnt_i(dcnt), .issue_o(issue), .cmd_o(cmd),
        .wclr_o(wclr), .dclr_o(dclr), .busy_o(busy_o), .done_o(done_o),
        .present_o(present_o), .err_to_o(err_timeout_o), .err_nd_o(err_nodev_o)
    );

    ate_access acc_i (
        .clk(clk), .rst(rst), .issue_i(issue), .cmd_i(cmd),
        .eng_req_o(eng_req_o), .eng_cmd_o(eng_cmd), .eng_done_i(eng_done_i),
        .eng_rdata_i(eng_rdata_i), .fin_o(fin), .rd_o(rd)
    );

    ate_ticker #(.W(TW)) wait_tmr_i (
        .clk(clk), .rst(rst), .clr_i(wclr), .tick_i(tick_i), .cnt_o(wcnt)
    );

    ate_ticker #(.W(DLW)) dead_tmr_i (
        .clk(clk), .rst(rst), .clr_i(dclr), .tick_i(tick_i), .cnt_o(dcnt)
    );

    assign eng_we_o    = eng_cmd.we;
    assign eng_reg_o   = eng_cmd.rsel;
    assign eng_wdata_o = eng_cmd.data;
endmodule

// File: rtl/ate_probe_chk.sv
module ate_probe_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       slave_ok_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       eng_req_o,
    input logic       eng_done_i,
    input logic       eng_we_o,
    input logic [3:0] eng_reg_o,
    input logic [7:0] eng_wdata_o,
    input logic [1:0] present_o,
    input logic       err_timeout_o,
    input logic       err_nodev_o
);
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        eng_req_o && !eng_done_i |=> eng_req_o);

    a_r12_cmd_stable: assert property (@(posedge clk) disable iff (rst)
        eng_req_o && !eng_done_i |=>
            $stable(eng_reg_o) && $stable(eng_we_o) && $stable(eng_wdata_o));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r11_req_in_run: assert property (@(posedge clk) disable iff (rst)
        eng_req_o |-> busy_o);

    a_r11_start_runs: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && !done_o |=> busy_o);

    a_r10_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(err_timeout_o && err_nodev_o));

    a_r5_no_slave: assert property (@(posedge clk) disable iff (rst)
        busy_o && !slave_ok_i |-> !present_o[1]);
endmodule

bind ate_probe_seq ate_probe_chk chk_i (
    .clk(clk), .rst(rst), .start_i(start_i), .slave_ok_i(slave_ok_i),
    .busy_o(busy_o), .done_o(done_o), .eng_req_o(eng_req_o),
    .eng_done_i(eng_done_i), .eng_we_o(eng_we_o), .eng_reg_o(eng_reg_o),
    .eng_wdata_o(eng_wdata_o), .present_o(present_o),
    .err_timeout_o(err_timeout_o), .err_nodev_o(err_nodev_o)
);

// File: tb/ate_probe_seq_tb.sv
`timescale 1ns/1ps
module ate_probe_seq_tb_top;
    localparam int DLW = 20;
    localparam int SRST_T = 5;
    localparam int SETTLE_T = 20;
    localparam int RETRY_T = 30;
    localparam int LIMIT_T = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic slave_ok = 1'b0;
    logic [7:0] ctl = 8'h0A;
    logic [DLW-1:0] limit = DLW'(LIMIT_T);
    logic tick = 1'b0;
    logic eng_req, eng_we, eng_done = 1'b0;
    logic [3:0] eng_reg;
    logic [7:0] eng_wdata, eng_rdata = 8'h00;
    logic busy, done;
    logic [1:0] present;
    logic err_to, err_nd;

    always #2 clk = ~clk;

    ate_probe_seq #(
        .DLW(DLW), .SRST_TICKS(SRST_T), .SETTLE_TICKS(SETTLE_T),
        .RETRY_TICKS(RETRY_T), .SIG_TRIES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .slave_ok_i(slave_ok),
        .ctl_i(ctl), .limit_i(limit), .tick_i(tick),
        .eng_req_o(eng_req), .eng_we_o(eng_we), .eng_reg_o(eng_reg),
        .eng_wdata_o(eng_wdata), .eng_done_i(eng_done), .eng_rdata_i(eng_rdata),
        .busy_o(busy), .done_o(done), .present_o(present),
        .err_timeout_o(err_to), .err_nodev_o(err_nd)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ticks = 0;
    bit finished = 0;

    // expected access list
    bit        exp_we [64];
    bit [3:0]  exp_reg[64];
    bit [7:0]  exp_dat[64];
    string     exp_tag[64];
    int        exp_n;
    int        stamp  [64];
    int        log_n;
    int        idx_c1, idx_poll0, idx_sig2;
    bit [1:0]  ex_pres;
    bit        ex_to, ex_nd;

    // device model
    bit   m_p[2];
    bit   m_sig, m_stuck0, m_gone1, m_after;
    bit   m_sel;
    bit [7:0] m_ns[2], m_lb[2];
    int   m_bleft[2];
    bit   pend_r, req_prev, last_r7;
    int   lat;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, expv, $time);
        end
    endtask

    function automatic bit [7:0] dev_rd(input bit [3:0] r);
        bit d;
        bit eff;
        d = m_sel;
        eff = m_p[d] && !(d && m_gone1 && m_after);
        if (!eff) return 8'hFF;
        case (r)
            4'h2: return m_ns[d];
            4'h3: return m_lb[d];
            4'h7: return ((d == 1'b0 && m_stuck0) || m_bleft[d] > 0) ? 8'h80 : 8'h50;
            default: return 8'h00;
        endcase
    endfunction

    task automatic dev_wr(input bit [3:0] r, input bit [7:0] v);
        bit d;
        bit eff;
        d = m_sel;
        eff = m_p[d] && !(d && m_gone1 && m_after);
        case (r)
            4'h6: m_sel = v[4];
            4'h2: if (eff) m_ns[d] = v;
            4'h3: if (eff) m_lb[d] = v;
            4'hE: if (v[2]) begin
                m_after = 1'b1;
                m_bleft[0] = 40;
                m_bleft[1] = 60;
                m_ns[0] = 8'h01; m_lb[0] = 8'h01;
                m_ns[1] = m_sig ? 8'h01 : 8'h00;
                m_lb[1] = m_sig ? 8'h01 : 8'h00;
            end
            default: ;
        endcase
    endtask

    // engine model, tick source and access monitor
    always @(negedge clk) begin
        cyc++;
        tick = (cyc % 4 == 0);
        if (tick) begin
            ticks++;
            for (int i = 0; i < 2; i++) if (m_bleft[i] > 0) m_bleft[i]--;
        end
        if (!rst && eng_req && !req_prev) begin
            if (!eng_we && eng_reg == 4'h7 && last_r7) begin
                // repeated poll read, folded into one entry
            end else begin
                if (log_n >= exp_n) begin
                    chk(1'b0, "R3 extra access", {eng_we, eng_reg}, 0);
                end else begin
                    chk(eng_we == exp_we[log_n] && eng_reg == exp_reg[log_n],
                        exp_tag[log_n], {eng_we, eng_reg}, {exp_we[log_n], exp_reg[log_n]});
                    if (exp_we[log_n])
                        chk(eng_wdata == exp_dat[log_n], exp_tag[log_n], eng_wdata, exp_dat[log_n]);
                    stamp[log_n] = ticks;
                end
                log_n++;
            end
            last_r7 = !eng_we && eng_reg == 4'h7;
        end
        req_prev = eng_req;
        if (eng_done) begin
            eng_done = 1'b0;
        end else if (eng_req && !pend_r) begin
            pend_r = 1'b1;
            lat = 1;
        end else if (pend_r) begin
            lat--;
            if (lat <= 0) begin
                chk(eng_req, "R12 request held", eng_req, 1);
                if (eng_we) dev_wr(eng_reg, eng_wdata);
                else        eng_rdata = dev_rd(eng_reg);
                eng_done = 1'b1;
                pend_r = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push(input bit we, input bit [3:0] r, input bit [7:0] d, input string tag);
        exp_we[exp_n] = we; exp_reg[exp_n] = r; exp_dat[exp_n] = d; exp_tag[exp_n] = tag;
        exp_n++;
    endtask

    task automatic push_probe(input bit [7:0] selv);
        push(1, 4'h6, selv, "R2 select");
        push(1, 4'h2, 8'h55, "R3 pattern"); push(1, 4'h3, 8'hAA, "R3 pattern");
        push(1, 4'h2, 8'hAA, "R3 pattern"); push(1, 4'h3, 8'h55, "R3 pattern");
        push(1, 4'h2, 8'h55, "R3 pattern"); push(1, 4'h3, 8'hAA, "R3 pattern");
        push(0, 4'h2, 8'h00, "R3 readback"); push(0, 4'h3, 8'h00, "R3 readback");
    endtask

    task automatic build(input bit p0, input bit p1, input bit sok, input bit sig,
                         input bit stuck0, input bit gone1);
        bit det1;
        det1 = sok && p1;
        exp_n = 0;
        idx_sig2 = -1;
        push_probe(8'hA0);
        if (sok) push_probe(8'hB0);
        push(1, 4'h6, 8'hA0, "R5 reselect dev0");
        idx_c1 = exp_n;
        push(1, 4'hE, 8'h0A, "R6 ctl");
        push(1, 4'hE, 8'h0E, "R6 ctl srst");
        push(1, 4'hE, 8'h0A, "R6 ctl release");
        idx_poll0 = exp_n;
        push(0, 4'h7, 8'h00, "R7 poll dev0");
        ex_pres = {det1, p0};
        ex_to = 0;
        ex_nd = 0;
        if (!p0) ex_nd = 1;
        else if (stuck0) ex_to = 1;
        else if (det1) begin
            push(1, 4'h6, 8'hB0, "R8 select dev1");
            push(0, 4'h2, 8'h00, "R8 sig"); push(0, 4'h3, 8'h00, "R8 sig");
            if (!sig || gone1) begin
                idx_sig2 = exp_n;
                push(0, 4'h2, 8'h00, "R8 sig retry"); push(0, 4'h3, 8'h00, "R8 sig retry");
            end
            push(0, 4'h7, 8'h00, "R8 poll dev1");
            if (gone1) ex_pres[1] = 0;
        end
    endtask

    task automatic run(input string name, input bit p0, input bit p1, input bit sok,
                       input bit sig, input bit stuck0, input bit gone1, input bit restart);
        int n;
        bit seen;
        m_p[0] = p0; m_p[1] = p1; m_sig = sig; m_stuck0 = stuck0; m_gone1 = gone1;
        m_after = 0; m_sel = 0; m_bleft[0] = 0; m_bleft[1] = 0;
        m_ns[0] = 0; m_ns[1] = 0; m_lb[0] = 0; m_lb[1] = 0;
        build(p0, p1, sok, sig, stuck0, gone1);
        log_n = 0;
        last_r7 = 0;
        slave_ok = sok;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R11 busy in run", busy, 1);
        if (restart) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 0;
        n = 0;
        while (!seen && n < 20000) begin
            @(negedge clk);
            if (done) seen = 1;
            n++;
        end
        chk(seen, {"R11 done seen ", name}, seen, 1);
        chk(busy == 1'b0, "R11 busy low at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", done, 0);
        chk(present == ex_pres, {"R4 presence ", name}, present, ex_pres);
        chk(err_to == ex_to, {"R10 timeout flag ", name}, err_to, ex_to);
        chk(err_nd == ex_nd, {"R9 nodev flag ", name}, err_nd, ex_nd);
        chk(log_n == exp_n, {"R3 access count ", name}, log_n, exp_n);
        if (log_n == exp_n) begin
            chk(stamp[idx_c1+1] - stamp[idx_c1] >= SRST_T, "R6 srst gap 1",
                stamp[idx_c1+1] - stamp[idx_c1], SRST_T);
            chk(stamp[idx_c1+2] - stamp[idx_c1+1] >= SRST_T, "R6 srst gap 2",
                stamp[idx_c1+2] - stamp[idx_c1+1], SRST_T);
            chk(stamp[idx_poll0] - stamp[idx_c1+2] >= SETTLE_T, "R7 settle gap",
                stamp[idx_poll0] - stamp[idx_c1+2], SETTLE_T);
            if (idx_sig2 >= 0)
                chk(stamp[idx_sig2] - stamp[idx_sig2-1] >= RETRY_T, "R8 retry gap",
                    stamp[idx_sig2] - stamp[idx_sig2-1], RETRY_T);
            if (ex_to)
                chk(ticks - stamp[idx_poll0] >= LIMIT_T, "R10 deadline length",
                    ticks - stamp[idx_poll0], LIMIT_T);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(done == 0, "R1 done after reset", done, 0);
        chk(eng_req == 0, "R1 req after reset", eng_req, 0);
        chk(present == 0, "R1 present after reset", present, 0);
        chk(err_to == 0 && err_nd == 0, "R1 errors after reset", {err_to, err_nd}, 0);

        run("both", 1, 1, 1, 1, 0, 0, 1);
        run("dev0 only", 1, 0, 1, 1, 0, 0, 0);
        run("no slave cfg", 1, 1, 0, 1, 0, 0, 0);
        run("dev1 slow sig", 1, 1, 1, 0, 0, 0, 0);
        run("dev0 stuck", 1, 1, 1, 1, 1, 0, 0);
        run("empty", 0, 0, 1, 1, 0, 0, 0);
        run("dev1 vanishes", 1, 1, 1, 1, 0, 1, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule